// File: doc/BRIEF.md
# B/D Channel Serial Multiplexer

This block carries the two 8-bit bearer bytes (B1 and B2) and the 2-bit signalling field (D) of each 125 µs frame between parallel per-frame registers and a four-wire serial time-division port. The port has a bit clock, a serial output line with an output enable, a serial input line and frame sync. Each frame sync opens a window of 18 consecutive bit slots: B1 first, then B2, then the two D bits.

In slave mode the bit clock and two independent frame syncs, one for each direction, are inputs. They are brought into the system clock domain by a synchronizer, so the transmit and receive frames may sit at any phase relative to each other. In master mode the block divides the system clock to make its own bit clock and drives one frame sync that both directions use. A format field sets the number of bit periods per frame, and with it the bit clock rate that a 125 µs frame needs. The transmit bytes are taken when a frame sync is seen. Each completed receive frame updates the output registers together with a single-cycle strobe.

Top module: `bdm_serial_mux`

## Requirements
- R1: After reset `dx_oe_o`, `rx_valid_o`, `bclk_o`, `fs_o` and the receive output registers are all 0.
- R2: A transmit frame sync seen high at a falling bit-clock edge causes the next 18 rising edges to drive `dx_o` with B1 MSB first, then B2 MSB first, then D bit 1 and then D bit 0. `dx_o` changes only after a rising edge.
- R3: `dx_oe_o` is 1 during exactly those 18 bit periods and 0 in every other bit period.
- R4: A receive frame sync seen high at a falling edge causes `dr_i` to be sampled on the next 18 falling edges, in the same order as R2. After the last bit, `rx_b1_o`, `rx_b2_o` and `rx_d_o` update together, and `rx_valid_o` is high for exactly one clock in that cycle. The outputs hold at all other times.
- R5: In slave mode the transmit and receive bit counters are restarted only by their own syncs (`fsx_i`, `fsr_i`), so frames with any phase skew between them both transfer correctly.
- R6: A frame sync that arrives during an active frame restarts that direction at bit 0. A transmit restart sends the full new frame. A receive restart discards the partial frame and gives no strobe for it.
- R7: In master mode `bclk_o` is high for HALF_DIV and low for HALF_DIV system clocks. `fs_o` rises together with `bclk_o` and stays high for one bit period. `fs_o` repeats every 32, 64, 256 or 320 bit periods for `fmt_i` = 0, 1, 2 or 3.
- R8: In master mode `fs_o` frames both directions, and `fsx_i`, `fsr_i` and `bclk_i` have no effect.
- R9: In slave mode `bclk_o` and `fs_o` stay 0.
- R10: The transmit bytes are captured when the frame sync is seen. Changing `tx_b1_i`, `tx_b2_i` or `tx_d_i` during the frame does not alter the bits sent in that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master_i | input | 1 | 1 selects master mode, 0 selects slave mode |
| fmt_i | input | 2 | Format select: bit periods per frame in master mode |
| bclk_i | input | 1 | Bit clock in slave mode |
| fsx_i | input | 1 | Transmit frame sync in slave mode |
| fsr_i | input | 1 | Receive frame sync in slave mode |
| dr_i | input | 1 | Serial receive data |
| bclk_o | output | 1 | Bit clock driven in master mode |
| fs_o | output | 1 | Shared frame sync driven in master mode |
| dx_o | output | 1 | Serial transmit data |
| dx_oe_o | output | 1 | Transmit output enable; 0 means high impedance |
| tx_b1_i | input | 8 | First bearer byte to send |
| tx_b2_i | input | 8 | Second bearer byte to send |
| tx_d_i | input | 2 | Signalling bits to send |
| rx_b1_o | output | 8 | First bearer byte received |
| rx_b2_o | output | 8 | Second bearer byte received |
| rx_d_o | output | 2 | Signalling bits received |
| rx_valid_o | output | 1 | Single-cycle strobe marking new receive data |

## Verification
The bench skews the receive sync five bit periods behind the transmit sync. A design that shares one counter between the directions would garble one of the two frames. It also sends a second sync partway through each direction's frame. A design that ignores the restart would send the old bytes, and one that keeps a partial frame would raise an extra strobe. It changes the transmit bytes just after the sync, which exposes a serializer that reads its inputs live instead of taking a snapshot. In master mode it measures the sync spacing in all four formats, where a wrong frame-length wrap shows up as a wrong cycle count, and it pulses the slave sync inputs during a frame, which a design that leaks the slave syncs into master mode would react to.

// File: rtl/bdm_pkg.sv
package bdm_pkg;

    typedef enum logic [1:0] {
        FMT_32B  = 2'd0,
        FMT_64B  = 2'd1,
        FMT_256B = 2'd2,
        FMT_320B = 2'd3
    } fmt_e;

    localparam int LEN_W = 9;

    // Bit periods per frame for each format code.
    function automatic logic [LEN_W-1:0] frame_len(input logic [1:0] f);
        case (fmt_e'(f))
            FMT_32B:  frame_len = 9'd32;
            FMT_64B:  frame_len = 9'd64;
            FMT_256B: frame_len = 9'd256;
            default:  frame_len = 9'd320;
        endcase
    endfunction

endpackage

// File: rtl/bdm_edge_sync.sv
module bdm_edge_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o,
    output logic             rise_o,
    output logic             fall_o
);
    // Bit 0 of async_i is the clock whose edges are reported.
    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] pipe;
        logic [WIDTH-1:0]             prev;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.pipe[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d.pipe[i] = st_q.pipe[i-1];
        end
        st_d.prev = st_q.pipe[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.pipe[STAGES-1];
    assign rise_o = sync_o[0] & ~st_q.prev[0];
    assign fall_o = ~sync_o[0] & st_q.prev[0];

endmodule

// File: rtl/bdm_clkgen.sv
module bdm_clkgen
    import bdm_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic [1:0] fmt_i,
    output logic       bclk_o,
    output logic       fs_o,
    output logic       rise_o,
    output logic       fall_o
);
    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             bclk;
        logic [LEN_W-1:0] idx;
        logic             fs;
        logic             rise;
        logic             fall;
    } st_t;

    st_t st_d, st_q;
    logic [LEN_W-1:0] len;

    assign len = frame_len(fmt_i);

    always_comb begin
        st_d      = st_q;
        st_d.rise = 1'b0;
        st_d.fall = 1'b0;
        if (!en_i) begin
            st_d = '0;
        end else if (st_q.div == DIV_W'(HALF_DIV - 1)) begin
            st_d.div  = '0;
            st_d.bclk = ~st_q.bclk;
            if (!st_q.bclk) begin
                st_d.rise = 1'b1;
                st_d.idx  = (st_q.idx >= len - 9'd1) ? '0 : st_q.idx + 9'd1;
                st_d.fs   = (st_d.idx == len - 9'd1);
            end else begin
                st_d.fall = 1'b1;
            end
        end else begin
            st_d.div = st_q.div + DIV_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bclk_o = st_q.bclk;
    assign fs_o   = st_q.fs;
    assign rise_o = st_q.rise;
    assign fall_o = st_q.fall;

endmodule

// File: rtl/bdm_tx.sv
module bdm_tx #(
    parameter int B_BITS = 8,
    parameter int D_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              fs_i,
    input  logic [B_BITS-1:0] b1_i,
    input  logic [B_BITS-1:0] b2_i,
    input  logic [D_BITS-1:0] d_i,
    output logic              dx_o,
    output logic              oe_o
);
    localparam int N  = 2 * B_BITS + D_BITS;
    localparam int PW = $clog2(N + 1);

    typedef struct packed {
        logic [N-1:0]  sh;
        logic [PW-1:0] pos;
        logic          dx;
        logic          oe;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fall_i && fs_i) begin
            st_d.sh  = {b1_i, b2_i, d_i};
            st_d.pos = '0;
        end else if (rise_i) begin
            if (st_q.pos < PW'(N)) begin
                st_d.dx  = st_q.sh[N-1];
                st_d.sh  = {st_q.sh[N-2:0], 1'b0};
                st_d.oe  = 1'b1;
                st_d.pos = st_q.pos + PW'(1);
            end else begin
                st_d.dx = 1'b0;
                st_d.oe = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.pos <= PW'(N);
        end else begin
            st_q <= st_d;
        end
    end

    assign dx_o = st_q.dx;
    assign oe_o = st_q.oe;

endmodule

// File: rtl/bdm_rx.sv
module bdm_rx #(
    parameter int B_BITS = 8,
    parameter int D_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall_i,
    input  logic              fs_i,
    input  logic              dr_i,
    output logic [B_BITS-1:0] b1_o,
    output logic [B_BITS-1:0] b2_o,
    output logic [D_BITS-1:0] d_o,
    output logic              vld_o
);
    localparam int N  = 2 * B_BITS + D_BITS;
    localparam int PW = $clog2(N + 1);

    typedef struct packed {
        logic [N-1:0]      sh;
        logic [PW-1:0]     pos;
        logic [B_BITS-1:0] b1;
        logic [B_BITS-1:0] b2;
        logic [D_BITS-1:0] dd;
        logic              vld;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (fall_i && fs_i) begin
            st_d.pos = '0;
        end else if (fall_i && (st_q.pos < PW'(N))) begin
            st_d.sh  = {st_q.sh[N-2:0], dr_i};
            st_d.pos = st_q.pos + PW'(1);
            if (st_q.pos == PW'(N - 1)) begin
                {st_d.b1, st_d.b2, st_d.dd} = st_d.sh;
                st_d.vld = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.pos <= PW'(N);
        end else begin
            st_q <= st_d;
        end
    end

    assign b1_o  = st_q.b1;
    assign b2_o  = st_q.b2;
    assign d_o   = st_q.dd;
    assign vld_o = st_q.vld;

endmodule

// File: rtl/bdm_serial_mux.sv
module bdm_serial_mux #(
    parameter int B_BITS      = 8,
    parameter int D_BITS      = 2,
    parameter int HALF_DIV    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_i,
    input  logic [1:0]        fmt_i,
    input  logic              bclk_i,
    input  logic              fsx_i,
    input  logic              fsr_i,
    input  logic              dr_i,
    output logic              bclk_o,
    output logic              fs_o,
    output logic              dx_o,
    output logic              dx_oe_o,
    input  logic [B_BITS-1:0] tx_b1_i,
    input  logic [B_BITS-1:0] tx_b2_i,
    input  logic [D_BITS-1:0] tx_d_i,
    output logic [B_BITS-1:0] rx_b1_o,
    output logic [B_BITS-1:0] rx_b2_o,
    output logic [D_BITS-1:0] rx_d_o,
    output logic              rx_valid_o
);
    localparam int SYNC_W = 4;

    logic [SYNC_W-1:0] port_sync;
    logic s_rise, s_fall;
    logic m_rise, m_fall;
    logic rise_sel, fall_sel, fsx_sel, fsr_sel;

    // Bit 0 carries the slave bit clock so its edges are detected.
    bdm_edge_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (SYNC_W)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({dr_i, fsr_i, fsx_i, bclk_i}),
        .sync_o  (port_sync),
        .rise_o  (s_rise),
        .fall_o  (s_fall)
    );

    bdm_clkgen #(
        .HALF_DIV (HALF_DIV)
    ) u_clkgen (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (master_i),
        .fmt_i  (fmt_i),
        .bclk_o (bclk_o),
        .fs_o   (fs_o),
        .rise_o (m_rise),
        .fall_o (m_fall)
    );

    always_comb begin
        if (master_i) begin
            rise_sel = m_rise;
            fall_sel = m_fall;
            fsx_sel  = fs_o;
            fsr_sel  = fs_o;
        end else begin
            rise_sel = s_rise;
            fall_sel = s_fall;
            fsx_sel  = port_sync[1];
            fsr_sel  = port_sync[2];
        end
    end

    bdm_tx #(
        .B_BITS (B_BITS),
        .D_BITS (D_BITS)
    ) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .rise_i (rise_sel),
        .fall_i (fall_sel),
        .fs_i   (fsx_sel),
        .b1_i   (tx_b1_i),
        .b2_i   (tx_b2_i),
        .d_i    (tx_d_i),
        .dx_o   (dx_o),
        .oe_o   (dx_oe_o)
    );

    bdm_rx #(
        .B_BITS (B_BITS),
        .D_BITS (D_BITS)
    ) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .fall_i (fall_sel),
        .fs_i   (fsr_sel),
        .dr_i   (port_sync[3]),
        .b1_o   (rx_b1_o),
        .b2_o   (rx_b2_o),
        .d_o    (rx_d_o),
        .vld_o  (rx_valid_o)
    );

endmodule

// File: rtl/bdm_serial_mux_chk.sv
module bdm_serial_mux_chk #(
    parameter int B_BITS = 8,
    parameter int D_BITS = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              master_i,
    input logic              bclk_o,
    input logic              fs_o,
    input logic              dx_o,
    input logic              dx_oe_o,
    input logic [B_BITS-1:0] rx_b1_o,
    input logic [B_BITS-1:0] rx_b2_o,
    input logic [D_BITS-1:0] rx_d_o,
    input logic              rx_valid_o
);
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!dx_oe_o && !rx_valid_o && !fs_o));

    assert_dx_moves_on_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (master_i && !bclk_o) |-> ($stable(dx_o) && $stable(dx_oe_o)));

    assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o);

    assert_rx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid_o |-> ($stable(rx_b1_o) && $stable(rx_b2_o) && $stable(rx_d_o)));

    assert_fs_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fs_o) |-> $rose(bclk_o));

    assert_slave_park_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_i && !$past(master_i)) |-> (!bclk_o && !fs_o));

endmodule

bind bdm_serial_mux bdm_serial_mux_chk #(
    .B_BITS (B_BITS),
    .D_BITS (D_BITS)
) u_chk (.*);

// File: tb/sim_bdm_serial_mux.sv
module sim_bdm_serial_mux;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_DIV   = 4;
    localparam int SB_HALF    = 8;
    localparam int N          = 18;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic master_i = 1'b0;
    logic [1:0] fmt_i = 2'd0;
    logic bclk_i = 1'b0, fsx_i = 1'b0, fsr_i = 1'b0, dr_i = 1'b0;
    logic bclk_o, fs_o, dx_o, dx_oe_o, rx_valid_o;
    logic [7:0] tx_b1_i = '0, tx_b2_i = '0, rx_b1_o, rx_b2_o;
    logic [1:0] tx_d_i = '0, rx_d_o;

    int vectors = 0;
    int fails = 0;
    int strobes = 0;
    logic [N-1:0] last_rx = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bdm_serial_mux #(.HALF_DIV(HALF_DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .master_i(master_i), .fmt_i(fmt_i),
        .bclk_i(bclk_i), .fsx_i(fsx_i), .fsr_i(fsr_i), .dr_i(dr_i),
        .bclk_o(bclk_o), .fs_o(fs_o), .dx_o(dx_o), .dx_oe_o(dx_oe_o),
        .tx_b1_i(tx_b1_i), .tx_b2_i(tx_b2_i), .tx_d_i(tx_d_i),
        .rx_b1_o(rx_b1_o), .rx_b2_o(rx_b2_o), .rx_d_o(rx_d_o),
        .rx_valid_o(rx_valid_o)
    );

    always @(negedge clk) begin
        if (rst_n && rx_valid_o) begin
            strobes = strobes + 1;
            last_rx = {rx_b1_o, rx_b2_o, rx_d_o};
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic m, input logic [1:0] f);
        rst_n = 1'b0; master_i = m; fmt_i = f;
        bclk_i = 0; fsx_i = 0; fsr_i = 0; dr_i = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // One slave bit period: rising edge, hold, falling edge, hold.
    task automatic sbit(input logic fx, input logic fr, input logic db,
                        output logic odx, output logic ooe, output logic park);
        bclk_i = 1; fsx_i = fx; fsr_i = fr; dr_i = db;
        repeat (SB_HALF - 1) @(negedge clk);
        odx = dx_o; ooe = dx_oe_o; park = !bclk_o && !fs_o;
        bclk_i = 0;
        repeat (SB_HALF) @(negedge clk);
    endtask

    task automatic wait_mrise();
        logic p = bclk_o;
        @(negedge clk);
        while (!(bclk_o && !p)) begin p = bclk_o; @(negedge clk); end
    endtask

    task automatic wait_mfall();
        logic p = bclk_o;
        @(negedge clk);
        while (!(!bclk_o && p)) begin p = bclk_o; @(negedge clk); end
    endtask

    task automatic wait_fs_rise();
        logic p = fs_o;
        @(negedge clk);
        while (!(fs_o && !p)) begin p = fs_o; @(negedge clk); end
    endtask

    task automatic t_reset();
        do_reset(1'b0, 2'd0);
        chk(dx_oe_o == 0, "R1 dx_oe", dx_oe_o, 0);
        chk(rx_valid_o == 0, "R1 rx_valid", rx_valid_o, 0);
        chk({rx_b1_o, rx_b2_o, rx_d_o} == 0, "R1 rx regs", {rx_b1_o, rx_b2_o, rx_d_o}, 0);
        chk(bclk_o == 0 && fs_o == 0, "R1 master outs", {bclk_o, fs_o}, 0);
    endtask

    // R2, R3, R9, R10: slave transmit of one frame with inputs changed after the sync.
    task automatic t_slave_tx();
        logic [N-1:0] exp = {8'hA5, 8'h3C, 2'b10};
        logic [N-1:0] got = '0;
        logic odx, ooe, pk;
        bit oe_ok = 1, park_ok = 1;
        do_reset(1'b0, 2'd0);
        tx_b1_i = 8'hA5; tx_b2_i = 8'h3C; tx_d_i = 2'b10;
        for (int p = 0; p < 22; p++) begin
            sbit(p == 0, 1'b0, 1'b0, odx, ooe, pk);
            if (p == 0) begin tx_b1_i = 8'hFF; tx_b2_i = 8'h00; tx_d_i = 2'b01; end
            if (!pk) park_ok = 0;
            if (p >= 1 && p <= N) begin
                got[N-p] = odx;
                if (!ooe) oe_ok = 0;
            end else if (ooe) oe_ok = 0;
        end
        chk(got == exp, "R2/R10 tx bit order and snapshot", got, exp);
        chk(oe_ok, "R3 output enable window", oe_ok, 1);
        chk(park_ok, "R9 slave keeps bclk_o/fs_o low", park_ok, 1);
    endtask

    task automatic t_slave_rx();
        logic [N-1:0] word = {8'h96, 8'h0F, 2'b01};
        logic odx, ooe, pk;
        int base;
        do_reset(1'b0, 2'd0);
        base = strobes;
        for (int p = 0; p < 21; p++) begin
            sbit(1'b0, p == 0, (p >= 1 && p <= N) ? word[N-p] : 1'b0, odx, ooe, pk);
            if (p == N - 1) chk(strobes == base, "R4 no early strobe", strobes - base, 0);
        end
        chk(strobes == base + 1, "R4 one strobe", strobes - base, 1);
        chk(last_rx == word, "R4 rx data", last_rx, word);
        chk({rx_b1_o, rx_b2_o, rx_d_o} == word, "R4 rx hold", {rx_b1_o, rx_b2_o, rx_d_o}, word);
    endtask

    task automatic t_skew();
        logic [N-1:0] txw = {8'h5A, 8'hC3, 2'b11};
        logic [N-1:0] rxw = {8'h81, 8'h7E, 2'b10};
        logic [N-1:0] got = '0;
        logic odx, ooe, pk;
        int base;
        do_reset(1'b0, 2'd0);
        tx_b1_i = 8'h5A; tx_b2_i = 8'hC3; tx_d_i = 2'b11;
        base = strobes;
        for (int p = 0; p < 27; p++) begin
            sbit(p == 0, p == 5, (p >= 6 && p <= 23) ? rxw[23-p] : 1'b1, odx, ooe, pk);
            if (p >= 1 && p <= N) got[N-p] = odx;
        end
        chk(got == txw, "R5 skewed tx frame", got, txw);
        chk(strobes == base + 1 && last_rx == rxw, "R5 skewed rx frame", last_rx, rxw);
    endtask

    task automatic t_restart();
        logic [N-1:0] f1 = {8'hF0, 8'hF0, 2'b11};
        logic [N-1:0] f2 = {8'h12, 8'h34, 2'b01};
        logic [N-1:0] rxw = {8'hE7, 8'h24, 2'b10};
        logic [4:0] head = '0;
        logic [N-1:0] got = '0;
        logic odx, ooe, pk, db;
        int base;
        do_reset(1'b0, 2'd0);
        tx_b1_i = 8'hF0; tx_b2_i = 8'hF0; tx_d_i = 2'b11;
        base = strobes;
        for (int p = 0; p < 28; p++) begin
            if (p == 3) begin tx_b1_i = 8'h12; tx_b2_i = 8'h34; tx_d_i = 2'b01; end
            db = (p >= 8 && p <= 25) ? rxw[25-p] : 1'b1;
            sbit(p == 0 || p == 5, p == 0 || p == 7, db, odx, ooe, pk);
            if (p >= 1 && p <= 5) head[5-p] = odx;
            if (p >= 6 && p <= 23) got[23-p] = odx;
        end
        chk(head == f1[N-1 -: 5], "R6 tx head of first frame", head, f1[N-1 -: 5]);
        chk(got == f2, "R6 tx restarted frame", got, f2);
        chk(strobes == base + 1, "R6 partial rx frame dropped", strobes - base, 1);
        chk(last_rx == rxw, "R6 rx restarted frame", last_rx, rxw);
    endtask

    task automatic t_master_timing(input logic [1:0] f, input int len);
        int hi, tot;
        do_reset(1'b1, f);
        wait_fs_rise();
        hi = 0;
        while (fs_o) begin @(negedge clk); hi++; end
        tot = hi;
        while (!fs_o) begin @(negedge clk); tot++; end
        chk(hi == 2*HALF_DIV, "R7 fs width", hi, 2*HALF_DIV);
        chk(tot == len*2*HALF_DIV, "R7 frame period", tot, len*2*HALF_DIV);
        wait_mrise();
        hi = 0;
        while (bclk_o) begin @(negedge clk); hi++; end
        chk(hi == HALF_DIV, "R7 bclk high time", hi, HALF_DIV);
    endtask

    task automatic t_master_xfer();
        logic [N-1:0] txw = {8'h69, 8'hB4, 2'b01};
        logic [N-1:0] rxw = {8'hC5, 8'h3A, 2'b11};
        logic [N-1:0] got = '0;
        bit oe_ok = 1;
        int base;
        do_reset(1'b1, 2'd0);
        tx_b1_i = 8'h69; tx_b2_i = 8'hB4; tx_d_i = 2'b01;
        base = strobes;
        wait_fs_rise();
        wait_mfall();
        for (int i = 0; i < N; i++) begin
            wait_mrise();
            dr_i = rxw[N-1-i];
            fsx_i = (i == 3); fsr_i = (i == 3); bclk_i = (i == 3);
            wait_mfall();
            got[N-1-i] = dx_o;
            if (!dx_oe_o) oe_ok = 0;
        end
        fsx_i = 0; fsr_i = 0; bclk_i = 0;
        wait_mrise();
        wait_mfall();
        if (dx_oe_o) oe_ok = 0;
        repeat (4) @(negedge clk);
        chk(got == txw, "R8 master tx frame", got, txw);
        chk(oe_ok, "R3/R8 master output enable window", oe_ok, 1);
        chk(strobes == base + 1 && last_rx == rxw, "R8 master rx frame", last_rx, rxw);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_slave_tx();
        t_slave_rx();
        t_skew();
        t_restart();
        t_master_timing(2'd0, 32);
        t_master_timing(2'd1, 64);
        t_master_timing(2'd2, 256);
        t_master_timing(2'd3, 320);
        t_master_xfer();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule